// File: doc/BRIEF.md
# Bus Grant Arbitration Timeout Timer

This block sits beside a bus arbiter and guards against grants that nobody uses. Each time the arbiter issues a grant it sends a one-cycle pulse to the block. The block then counts clock cycles while it watches the active-low bus-busy line. If no master pulls the line low within the 410 µs window, the block drives bus-busy itself for a fixed number of cycles and then lets go. That release edge returns the arbiter to idle, so any requests still pending are arbitrated again.

The window length is not set directly. It is derived from a clock-frequency parameter, rounded up to whole cycles. A small enable register gates the whole function. The register comes out of reset set, so the timer is active without any configuration. The request and grant logic of the arbiter is outside this block.

All pins are plain control signals. No data passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `grant_timeout_timer`

## Requirements
- R1: After reset `busy_drive` and `timeout_pulse` are 0 and the enable register holds 1, so a grant with no prior configuration leads to a timeout.
- R2: If a grant is sampled at clock edge E and `bus_busy_n` stays high, `busy_drive` rises after edge E+LIMIT. LIMIT is CLK_HZ × 410 µs rounded up, which is 41 cycles at CLK_HZ = 100 000.
- R3: `timeout_pulse` is high for exactly one cycle: the first cycle in which `busy_drive` is high.
- R4: Once raised, `busy_drive` stays high for exactly HOLD_CYCLES cycles, then returns to 0.
- R5: A low `bus_busy_n` sampled at any edge E+1 … E+LIMIT cancels the pending timeout. This includes the expiry edge E+LIMIT itself, where the external busy takes priority over the timeout.
- R6: While the enable register holds 0, grants are ignored. Clearing the register while a window is open abandons that window.
- R7: A grant sampled while a window is open restarts the window from that edge.
- R8: A grant that arrives while the block is driving bus-busy is ignored. After the release no further timeout occurs.
- R9: A grant sampled while `bus_busy_n` is already low opens no window.
- R10: `cfg_we` = 1 loads `cfg_en` into the enable register at the next edge. While `cfg_we` = 0 the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the enable register |
| cfg_en | input | 1 | Value loaded into the enable register |
| grant_pulse | input | 1 | One-cycle pulse when the arbiter issues a grant |
| bus_busy_n | input | 1 | Sensed bus-busy line, active low |
| busy_drive | output | 1 | 1 = pull the bus-busy line low |
| timeout_pulse | output | 1 | One-cycle flag on each timeout event |

## Verification
Two events can land on the same edge: an outside master asserting bus-busy, and the window expiring. The bench sweeps the edge at which external busy first appears across every position from the first cycle after the grant to one cycle past expiry. At every position up to and including the expiry edge it expects no timeout. At the position past expiry it expects exactly one timeout. A second collision is also provoked: a fresh grant on the expiry edge, which must restart the window rather than fire.

// File: rtl/gtt_pkg.sv
package gtt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2
  } gtt_state_e;

  function automatic longint cycles_for_ns(longint clk_hz, longint ns);
    longint c;
    c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction
endpackage

// File: rtl/gtt_enable_reg.sv
module gtt_enable_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wdata,
  output logic en
);
  always_ff @(posedge clk) begin
    if (!rst_n)  en <= 1'b1;
    else if (we) en <= wdata;
  end
endmodule

// File: rtl/gtt_cycle_counter.sv
module gtt_cycle_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) count <= '0;
    else if (inc)      count <= count + 1'b1;
  end
endmodule

// File: rtl/gtt_ctrl.sv
module gtt_ctrl
  import gtt_pkg::*;
#(
  parameter int W     = 8,
  parameter int LIMIT = 41,
  parameter int HOLD  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         grant,
  input  logic         busy_n,
  input  logic [W-1:0] count,
  output logic         cnt_clr,
  output logic         cnt_inc,
  output logic         drive,
  output logic         fire_q
);
  localparam logic [W-1:0] LIMIT_LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] HOLD_LAST  = W'(HOLD - 1);

  gtt_state_e state_q, state_d;
  logic       restart;
  logic       fire;

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    fire    = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (en && grant && busy_n) state_d = ST_WAIT;
      ST_WAIT:
        if (!busy_n || !en)              state_d = ST_IDLE;
        else if (grant)                  restart = 1'b1;
        else if (count == LIMIT_LAST) begin
          state_d = ST_DRIVE;
          fire    = 1'b1;
        end
      ST_DRIVE:
        if (count == HOLD_LAST) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = (state_d != state_q) || restart;
  assign cnt_inc = (state_q != ST_IDLE);
  assign drive   = (state_q == ST_DRIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fire_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fire_q  <= fire;
    end
  end
endmodule

// File: rtl/grant_timeout_timer.sv
module grant_timeout_timer #(
  parameter longint CLK_HZ      = 50_000_000,
  parameter longint TIMEOUT_NS  = 410_000,
  parameter int     HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_en,
  input  logic grant_pulse,
  input  logic bus_busy_n,
  output logic busy_drive,
  output logic timeout_pulse
);
  localparam longint LIMIT_L = gtt_pkg::cycles_for_ns(CLK_HZ, TIMEOUT_NS);
  localparam int     LIMIT   = int'(LIMIT_L);
  localparam int     HOLD    = (HOLD_CYCLES < 1) ? 1 : HOLD_CYCLES;
  localparam int     SPAN    = (LIMIT > HOLD) ? LIMIT : HOLD;
  localparam int     CW      = $clog2(SPAN + 1);

  logic          en;
  logic          cnt_clr, cnt_inc;
  logic [CW-1:0] count;

  gtt_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_en), .en(en)
  );

  gtt_cycle_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .count(count)
  );

  gtt_ctrl #(.W(CW), .LIMIT(LIMIT), .HOLD(HOLD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .grant(grant_pulse),
    .busy_n(bus_busy_n), .count(count), .cnt_clr(cnt_clr),
    .cnt_inc(cnt_inc), .drive(busy_drive), .fire_q(timeout_pulse)
  );
endmodule

// File: rtl/gtt_checker.sv
module gtt_checker #(
  parameter int HOLD_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic bus_busy_n,
  input logic busy_drive,
  input logic timeout_pulse
);
  int run;
  always_ff @(posedge clk) begin
    if (!rst_n)          run <= 0;
    else if (busy_drive) run <= run + 1;
    else                 run <= 0;
  end

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  assert_pulse_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> (busy_drive && run == 0));

  assert_rise_flagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_drive && run == 0) |-> timeout_pulse);

  assert_hold_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_drive && run == HOLD_CYCLES - 1) |=> !busy_drive);

  assert_hold_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_drive && run < HOLD_CYCLES - 1) |=> busy_drive);

  assert_busy_cancels_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy_n && !busy_drive) |=> !timeout_pulse);
endmodule

bind grant_timeout_timer gtt_checker #(.HOLD_CYCLES(HOLD)) u_gtt_chk (
  .clk(clk), .rst_n(rst_n), .bus_busy_n(bus_busy_n),
  .busy_drive(busy_drive), .timeout_pulse(timeout_pulse)
);

// File: tb/grant_timeout_timer_bench.sv
module grant_timeout_timer_bench;
  localparam int LIMIT = 41;
  localparam int HOLD  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, grant = 1'b0, ext_busy = 1'b0;
  logic busy_drive, timeout_pulse, bus_busy_n;
  int   total = 0, bad = 0, to_seen = 0, drv_seen = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;
  assign bus_busy_n = ~(ext_busy | busy_drive);

  grant_timeout_timer #(.CLK_HZ(100_000), .TIMEOUT_NS(410_000), .HOLD_CYCLES(HOLD))
    u_grant_timeout_timer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en),
      .grant_pulse(grant), .bus_busy_n(bus_busy_n),
      .busy_drive(busy_drive), .timeout_pulse(timeout_pulse));

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (timeout_pulse) to_seen++;
      if (busy_drive)    drv_seen++;
    end
  endtask

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_grant();
    grant = 1'b1; tick(); grant = 1'b0;
  endtask

  task automatic clear_seen();
    to_seen = 0; drv_seen = 0;
  endtask

  task automatic write_en(bit v);
    cfg_we = 1'b1; cfg_en = v; tick(); cfg_we = 1'b0;
  endtask

  initial begin
    #(20 * 200_000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(2); rst_n = 1'b1;
    check("R1 drive after reset", busy_drive, 0);
    check("R1 pulse after reset", timeout_pulse, 0);

    // R1/R2/R3/R4: default-enabled full timeout with exact timing
    clear_seen();
    do_grant();
    tick(LIMIT - 1);
    check("R2 no drive before expiry", busy_drive, 0);
    tick();
    check("R2 drive at expiry", busy_drive, 1);
    check("R3 pulse on first drive cycle", timeout_pulse, 1);
    tick();
    check("R3 pulse one cycle", timeout_pulse, 0);
    tick(HOLD - 2);
    check("R4 still driving last hold cycle", busy_drive, 1);
    tick();
    check("R4 released after hold", busy_drive, 0);
    check("R4 hold length", drv_seen, HOLD);
    tick(3);

    // R5: sweep first external-busy edge k = 1 .. LIMIT+1
    for (int k = 1; k <= LIMIT + 1; k++) begin
      clear_seen();
      do_grant();
      tick(k - 1);
      ext_busy = 1'b1; tick(); ext_busy = 1'b0;
      tick(LIMIT + HOLD + 2);
      check($sformatf("R5 busy at edge %0d timeouts", k), to_seen, (k > LIMIT) ? 1 : 0);
    end

    // R6/R10: disabled -> grant ignored
    write_en(1'b0);
    clear_seen();
    do_grant(); tick(LIMIT + HOLD + 2);
    check("R6 disabled grant ignored", to_seen, 0);
    check("R10 enable write took effect", drv_seen, 0);
    write_en(1'b1);

    // R6: clearing enable mid-window abandons it
    clear_seen();
    do_grant(); tick(10);
    write_en(1'b0); write_en(1'b1);
    tick(LIMIT + HOLD + 2);
    check("R6 disable mid-window", to_seen, 0);

    // R10: strobe low keeps value (cfg_en toggled without we)
    clear_seen();
    cfg_en = 1'b0; tick(2);
    do_grant(); tick(LIMIT + HOLD + 2);
    check("R10 no write without strobe", to_seen, 1);

    // R7: regrant restarts window; also regrant on the expiry edge
    for (int g = 10; g <= LIMIT; g += LIMIT - 10) begin
      clear_seen();
      do_grant(); tick(g - 1);
      do_grant();
      tick(LIMIT - 1);
      check($sformatf("R7 regrant at %0d no drive early", g), busy_drive, 0);
      tick();
      check($sformatf("R7 regrant at %0d drive", g), busy_drive, 1);
      tick(HOLD + 2);
    end

    // R8: grant during drive ignored
    clear_seen();
    do_grant(); tick(LIMIT + 1);
    do_grant();
    tick(LIMIT + HOLD + 4);
    check("R8 grant during drive ignored", to_seen, 1);

    // R9: grant with bus already busy
    clear_seen();
    ext_busy = 1'b1; do_grant(); ext_busy = 1'b0;
    tick(LIMIT + HOLD + 2);
    check("R9 grant while busy ignored", to_seen, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule